// File: doc/BRIEF.md
# SPI Peripheral Serial Byte Engine

This block is the serial front end of an SPI peripheral working in clock mode 0. The host owns the serial clock and an active-low select. The engine samples the host-out line on each rising serial-clock edge and assembles those bits, most significant first, into bytes. It offers each finished byte on a valid/ready output stream. In the other direction it takes bytes from a valid/ready input stream and drives their bits onto the host-in line, changing that line only on falling serial-clock edges.

The serial pins are treated as already synchronous to the system clock `clk`. The engine finds serial-clock edges by comparing each sample with the one before it, so a host may stall the serial clock for any length of time in the middle of a byte. Serial-clock edges outside a select frame are ignored, and a select pulse with no clock edges in it changes nothing. When a frame ends early, a transmit byte that the host has only partly read is kept and sent again from its top bit in the next frame. Once the host has read all but the last bit, the byte is treated as used. An empty transmit stream yields a filler byte and an underflow pulse. A full receive stream drops the new byte and yields an overflow pulse.

Top module: `spi_byte_engine`

## Requirements
- R1: After reset `spi_miso`, `rx_valid`, `tx_underflow` and `rx_overflow` are 0, and `tx_ready` is 1 while select is high and no transmit byte is held.
- R2: Within a frame the bit sampled on the k-th rising `spi_sck` edge is bit 7-k of a received byte (MSB first). After 8 edges the byte appears on `rx_data` with `rx_valid`. `spi_miso` changes only at a select falling edge or a `spi_sck` falling edge.
- R3: Consecutive transmit bytes in one frame follow each other with no idle bit. The next byte is taken from the stream at the falling edge that launches bit 0 of the current byte.
- R4: `spi_sck` edges while `spi_cs_n` is high change no bit count, no shift state and no stream handshake.
- R5: A select low pulse with no `spi_sck` edge emits no received byte, uses no transmit byte and raises no pulse.
- R6: Stopping `spi_sck` for any time with select low, then resuming, continues both directions from the same bit with no loss or repeat.
- R7: If fewer than 7 bits of a transmit byte were sampled by the host when select rises, the next frame starts with that same byte.
- R8: If 7 or 8 bits of a transmit byte were sampled when select rises, that byte is used and the next frame starts with the following stream byte.
- R9: A byte position with no stream data shifts out the filler value (default 8'hFF). `tx_underflow` pulses for one cycle on the first rising edge of each such filler byte.
- R10: A byte that completes while `rx_valid` is high and `rx_ready` is low is dropped, `rx_overflow` pulses for one cycle, and the held byte stays unchanged.
- R11: Bits of a received byte that is incomplete when select rises are dropped, and the next frame starts a fresh byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Host serial clock, idles low |
| spi_cs_n | input | 1 | Host select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| rx_data | output | DW | Received byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer accepts received byte |
| tx_data | input | DW | Byte to transmit |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Engine accepts transmit byte |
| tx_underflow | output | 1 | One-cycle pulse: filler byte started |
| rx_overflow | output | 1 | One-cycle pulse: received byte dropped |

## Verification
The assertions assume that the serial pins are stable across each system-clock edge and that a serial-clock edge and a select edge never occur in the same cycle. The bench drives every serial pin on the falling system-clock edge and holds each serial-clock level for four cycles, so both assumptions hold. The bench samples `spi_miso` before each rising serial edge, which is at least four cycles after the falling edge that set it. It keeps the stream handshakes stable across the window in which it samples them.

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int DW = 8,
  parameter logic [DW-1:0] FILL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic          tx_underflow,
  output logic          rx_overflow
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          sck_q, cs_n_q, fetched, have;
  logic [CW-1:0] bcnt;
  logic [DW-1:0] cur, rx_sh;

  wire          sel     = ~spi_cs_n;
  wire          rise    = sel & spi_sck & ~sck_q;
  wire          fall    = sel & ~spi_sck & sck_q;
  wire          start   = sel & cs_n_q;
  wire          stop    = spi_cs_n & ~cs_n_q;
  wire          last    = (bcnt == LAST);
  wire          fetch   = fall & last;
  wire [DW-1:0] eff     = have ? cur : FILL;
  wire [DW-1:0] rx_byte = {rx_sh[DW-2:0], spi_mosi};
  wire          rx_take = ~rx_valid | rx_ready;

  assign tx_ready = fetch | (spi_cs_n & ~have);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q        <= 1'b0;
      cs_n_q       <= 1'b1;
      fetched      <= 1'b0;
      have         <= 1'b0;
      bcnt         <= '0;
      cur          <= '0;
      rx_sh        <= '0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      spi_miso     <= 1'b0;
      tx_underflow <= 1'b0;
      rx_overflow  <= 1'b0;
    end else begin
      sck_q        <= spi_sck;
      cs_n_q       <= spi_cs_n;
      tx_underflow <= 1'b0;
      rx_overflow  <= 1'b0;

      if (stop) begin
        bcnt    <= '0;
        fetched <= 1'b0;
        if (last && !fetched) have <= 1'b0;
      end
      if (spi_cs_n && !have && tx_valid) begin
        cur  <= tx_data;
        have <= 1'b1;
      end

      if (start) spi_miso <= eff[DW-1];

      if (rise) begin
        rx_sh   <= rx_byte;
        bcnt    <= last ? '0 : bcnt + 1'b1;
        fetched <= 1'b0;
        if (bcnt == '0 && !have) tx_underflow <= 1'b1;
        if (last && !rx_take) rx_overflow <= 1'b1;
      end

      if (fall) begin
        spi_miso <= eff[LAST - bcnt];
        if (last) begin
          fetched <= 1'b1;
          have    <= tx_valid;
          if (tx_valid) cur <= tx_data;
        end
      end

      if (rise && last && rx_take) begin
        rx_data  <= rx_byte;
        rx_valid <= 1'b1;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n && cs_n_q |-> bcnt == '0 && !fetched); // R4
  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fall) && !$past(start) |-> $stable(spi_miso)); // R2
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R10
  AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underflow || rx_overflow |-> $past(rise)); // R5
  AST_RX_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(rise && last)); // R11
endmodule

// File: tb/test_spi_byte_engine.sv
module test_spi_byte_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic clk = 0, rst_n = 0;
  logic spi_sck = 0, spi_cs_n = 1, spi_mosi = 0, spi_miso;
  logic [7:0] rx_data, tx_data = 0;
  logic rx_valid, rx_ready = 1, tx_valid = 0, tx_ready, tx_underflow, rx_overflow;

  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int n_tests = 0, n_fail = 0, uf_cnt = 0, of_cnt = 0;

  always #(HALF) clk = ~clk;

  spi_byte_engine i_spi_byte_engine (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_underflow(tx_underflow),
    .rx_overflow(rx_overflow));

  initial forever begin
    @(negedge clk);
    tx_valid = (txq.size() > 0);
    tx_data  = tx_valid ? txq[0] : 8'h00;
    #(HALF - 1);
    if (rst_n && tx_valid && tx_ready) void'(txq.pop_front());
  end

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      uf_cnt += int'(tx_underflow);
      of_cnt += int'(rx_overflow);
    end
    #(HALF - 1);
    if (rst_n && rx_valid && rx_ready) rxq.push_back(rx_data);
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; spi_cs_n = 1; spi_sck = 0; spi_mosi = 0; rx_ready = 1;
    txq.delete(); rxq.delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
    uf_cnt = 0; of_cnt = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sck_pulse();
    spi_sck = 1; repeat (4) @(negedge clk);
    spi_sck = 0; repeat (4) @(negedge clk);
  endtask

  task automatic frame(input int nbits, input logic [63:0] mo, input int pause_at,
                       output logic [63:0] mi);
    mi = '0;
    @(negedge clk) spi_cs_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (pause_at > 0 && (i == pause_at || i == pause_at + 8)) repeat (50) @(negedge clk);
      spi_mosi = mo[63-i];
      mi[63-i] = spi_miso;
      sck_pulse();
    end
    spi_cs_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] mi, mi2, exp64;
    logic [7:0] a, b;

    do_reset();
    chk("R1 miso", 64'(spi_miso), 0);
    chk("R1 rx_valid", 64'(rx_valid), 0);
    chk("R1 pulses", 64'({tx_underflow, rx_overflow}), 0);
    chk("R1 tx_ready", 64'(tx_ready), 1);

    // R7 / R8 / R5 / R11: sweep of bits sent before select rises
    for (int n = 0; n <= 8; n++) begin
      do_reset();
      a = 8'h3C ^ 8'(n * 17);
      b = 8'hC5 + 8'(n);
      txq.push_back(a); txq.push_back(b);
      frame(n, {8'h96, 56'h0}, 0, mi);
      if (n > 0) chk("R2 partial bits", mi >> (64 - n), 64'(a >> (8 - n)));
      frame(8, {8'h5A ^ 8'(n), 56'h0}, 0, mi2);
      chk(n == 0 ? "R5 tx kept" : (n < 7 ? "R7 resend" : "R8 consumed"),
          64'(mi2[63:56]), 64'(n < 7 ? a : b));
      chk(n == 0 ? "R5 rx count" : "R11 rx count", 64'(rxq.size()), 64'(n == 8 ? 2 : 1));
      chk("R2 rx byte", 64'(rxq[rxq.size()-1]), 64'(8'h5A ^ 8'(n)));
      chk(n == 0 ? "R5 no pulse" : "R9 no pulse", 64'(uf_cnt + of_cnt), 0);
    end

    // R4: stray serial clock with select high between frames
    do_reset();
    txq.push_back(8'hE7);
    repeat (6) sck_pulse();
    frame(3, 64'h0, 0, mi);
    repeat (6) sck_pulse();
    chk("R4 no rx", 64'(rxq.size()), 0);
    frame(8, {8'h71, 56'h0}, 0, mi2);
    chk("R4 tx unchanged", 64'(mi2[63:56]), 64'(8'hE7));
    chk("R4 rx aligned", 64'(rxq.size() == 1 ? rxq[0] : 8'h00), 64'(8'h71));
    chk("R4 no pulse", 64'(uf_cnt + of_cnt), 0);

    // R6 / R3: pauses inside bytes
    do_reset();
    txq.push_back(8'h1B); txq.push_back(8'hD4);
    frame(16, {16'hB38E, 48'h0}, 3, mi);
    chk("R6 tx stream", 64'(mi[63:48]), 64'(16'h1BD4));
    chk("R6 rx count", 64'(rxq.size()), 2);
    chk("R6 rx bytes", 64'({rxq[0], rxq[1]}), 64'(16'hB38E));

    // R3: eight back-to-back bytes in one frame
    do_reset();
    exp64 = '0;
    for (int k = 0; k < 8; k++) begin
      txq.push_back(8'(k * 37 + 5));
      exp64 = {exp64[55:0], 8'(k * 37 + 5)};
    end
    frame(64, 64'hF00D_1234_ABCD_5A69, 0, mi);
    chk("R3 tx stream", mi, exp64);
    chk("R3 rx count", 64'(rxq.size()), 8);
    for (int k = 0; k < 8; k++)
      if (k < rxq.size()) chk("R3 rx byte", 64'(rxq[k]), 64'(8'(64'hF00D_1234_ABCD_5A69 >> (56 - 8*k))));
    chk("R3 no pulse", 64'(uf_cnt), 0);

    // R9: empty stream
    do_reset();
    frame(8, 64'h0, 0, mi);
    chk("R9 filler", 64'(mi[63:56]), 64'(8'hFF));
    chk("R9 pulse", 64'(uf_cnt), 1);
    txq.push_back(8'h42);
    repeat (4) @(negedge clk);
    frame(16, 64'h0, 0, mi);
    chk("R9 data then filler", 64'(mi[63:48]), 64'(16'h42FF));
    chk("R9 second pulse", 64'(uf_cnt), 2);

    // R10: receive stream blocked
    do_reset();
    rx_ready = 0;
    txq.push_back(8'h11); txq.push_back(8'h22);
    frame(16, {16'h6DA1, 48'h0}, 0, mi);
    chk("R10 pulse", 64'(of_cnt), 1);
    chk("R10 held", 64'({rx_valid, rx_data}), 64'({1'b1, 8'h6D}));
    rx_ready = 1;
    repeat (3) @(negedge clk);
    chk("R10 delivered", 64'(rxq.size()), 1);
    chk("R10 first kept", 64'(rxq.size() > 0 ? rxq[0] : 8'h00), 64'(8'h6D));

    summary();
    $finish;
  end
endmodule